// File: doc/BRIEF.md
# Parallel Bit Scatter Unit

This datapath block takes a source word and a selection mask and spreads the lowest bits of the source, one after another, into the result positions where the mask holds a 1. Every result position whose mask bit is 0 is cleared. The source bit that lands at a given result position is the one whose index equals the number of mask ones below that position. A prefix-count network computes that number for every position in parallel, so the result is ready in a single cycle.

Mode controls set the operand width and flag illegal requests. The width is 64 bits only when the unit is in long mode and the width select bit is 1. Otherwise it is 32 bits: the upper halves of the source and the mask are ignored and the upper half of the result is zero. A request is illegal when the vector-length bit is set or when the unit is in legacy (real or virtual-8086) mode. An illegal request returns a zero result with the illegal flag raised. The unit has no status-flag output, so no flags change.

Control is a two-state machine. In `ST_IDLE` no result is presented. Accepting a request (`in_valid` high) moves it to `ST_DONE`. In `ST_DONE` the registered result is presented with `out_valid`. The machine goes back to `ST_IDLE` on the first cycle without a request and stays in `ST_DONE` while requests keep arriving.

Top module: `bit_scatter_unit`

## Requirements
- R1: For each result bit i whose effective mask bit is 1, the result bit equals source bit k, where k is the count of effective mask ones at positions below i.
- R2: Every result bit whose mask bit is 0 is zero.
- R3: When `long_mode` is 0 the operation is 32 bits wide, whatever the value of `wide_sel`.
- R4: When `long_mode` is 1, the operation is 64 bits wide if `wide_sel` is 1 and 32 bits wide if `wide_sel` is 0.
- R5: In a 32-bit operation, source and mask bits 63:32 have no effect and result bits 63:32 are zero.
- R6: `bad_op` is 1 for a request with `vlen_bit` = 1 or `legacy_mode` = 1, and 0 for any other request.
- R7: Whenever `bad_op` is 1, `res_data` is zero.
- R8: `out_valid` equals `in_valid` of the previous cycle. Results appear one clock after the request.
- R9: A synchronous reset puts the machine in `ST_IDLE` and clears `out_valid` and `bad_op`. An in-flight request is dropped.
- R10: An all-zero mask gives a zero result. An all-ones mask returns the source unchanged over the active width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| src_data | input | 64 | Source operand whose low bits are scattered |
| sel_mask | input | 64 | Mask selecting destination positions |
| long_mode | input | 1 | Unit is in long (64-bit) mode |
| legacy_mode | input | 1 | Unit is in real or virtual-8086 mode |
| wide_sel | input | 1 | Width select bit; 1 asks for 64 bits |
| vlen_bit | input | 1 | Vector-length bit; must be 0 |
| out_valid | output | 1 | Registered result is valid |
| res_data | output | 64 | Scattered result |
| bad_op | output | 1 | Request was illegal; result forced to zero |

## Verification
The hardest cases to reach are those where the source index of a high result bit depends on a long run of mask ones below it. The index of bit 63 is only exercised when nearly every mask bit is set, and a sparse random mask seldom produces that. The stimulus therefore includes all-ones and two-ends masks as well as the worked sparse example. It also runs a random sweep that sometimes draws each mask half as all ones, and compares every result with a loop-based model. The 32-bit path is driven with garbage in the upper source and mask halves, to show that those halves are ignored in both long and non-long mode.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
    localparam int unsigned BSU_DATA_W = 64;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } bsu_state_e;
endpackage

// File: rtl/bsu_mode_decode.sv
module bsu_mode_decode (
    input  logic long_mode,
    input  logic legacy_mode,
    input  logic wide_sel,
    input  logic vlen_bit,
    output logic use_full,
    output logic illegal
);
    // R3 / R4: full width only in long mode with the width select set
    assign use_full = long_mode & wide_sel;
    // R6: vector-length bit or legacy mode makes the request illegal
    assign illegal  = vlen_bit | legacy_mode;
endmodule

// File: rtl/bsu_deposit_net.sv
module bsu_deposit_net #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] src,
    input  logic [W-1:0] mask,
    output logic [W-1:0] res
);
    localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;

    // cnt[i] = number of mask ones strictly below position i (R1)
    logic [IDX_W-1:0] cnt [W];

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_first
            assign cnt[i] = '0;
        end else begin : g_rest
            assign cnt[i] = cnt[i-1] + IDX_W'(mask[i-1]);
        end
        // R2: unselected positions stay zero
        assign res[i] = mask[i] & src[cnt[i]];
    end
endmodule

// File: rtl/bit_scatter_unit.sv
module bit_scatter_unit
    import bsu_pkg::*;
#(
    parameter int unsigned DATA_W = BSU_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic [DATA_W-1:0] sel_mask,
    input  logic              long_mode,
    input  logic              legacy_mode,
    input  logic              wide_sel,
    input  logic              vlen_bit,
    output logic              out_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              bad_op
);
    localparam int unsigned HALF_W = DATA_W / 2;

    bsu_state_e        state_q;
    bsu_state_e        state_d;
    logic              use_full;
    logic              illegal;
    logic [DATA_W-1:0] eff_src;
    logic [DATA_W-1:0] eff_mask;
    logic [DATA_W-1:0] dep_res;
    logic [DATA_W-1:0] res_q;
    logic              bad_q;

    bsu_mode_decode u_mode (
        .long_mode  (long_mode),
        .legacy_mode(legacy_mode),
        .wide_sel   (wide_sel),
        .vlen_bit   (vlen_bit),
        .use_full   (use_full),
        .illegal    (illegal)
    );

    // R5: the narrow width drops the upper halves before the network
    always_comb begin
        if (use_full) begin
            eff_src  = src_data;
            eff_mask = sel_mask;
        end else begin
            eff_src  = {{(DATA_W-HALF_W){1'b0}}, src_data[HALF_W-1:0]};
            eff_mask = {{(DATA_W-HALF_W){1'b0}}, sel_mask[HALF_W-1:0]};
        end
    end

    bsu_deposit_net #(.W(DATA_W)) u_net (
        .src (eff_src),
        .mask(eff_mask),
        .res (dep_res)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_DONE;
            ST_DONE: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            bad_q <= 1'b0;
        end else if (in_valid) begin
            res_q <= illegal ? '0 : dep_res;
            bad_q <= illegal;
        end else begin
            bad_q <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_DONE);
    assign res_data  = res_q;
    assign bad_op    = bad_q;

    // assertions
    p_valid_rise_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_fall_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_unmasked_zero_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((res_data & ~$past(sel_mask)) == '0));
    p_narrow_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(long_mode && wide_sel)) |=> (res_data[DATA_W-1:HALF_W] == '0));
    p_bad_flag_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (bad_op == $past(vlen_bit || legacy_mode)));
    p_bad_zero_r7: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> (res_data == '0));
    p_bad_needs_valid_r6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !bad_op);
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!out_valid && !bad_op));
endmodule

// File: tb/sim_bit_scatter_unit.sv
module sim_bit_scatter_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] mask;
        logic        lm;
        logic        leg;
        logic        wide;
        logic        vl;
        logic [63:0] exp;
        logic        exp_bad;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R1 worked example: mask 1,4,6,8 ; src 1010b -> bits 4 and 8
        '{64'hA, 64'h152, 1'b1, 1'b0, 1'b1, 1'b0, 64'h110, 1'b0},
        // R10 all ones, 64-bit
        '{64'hDEAD_BEEF_0123_4567, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0,
          64'hDEAD_BEEF_0123_4567, 1'b0},
        // R10 zero mask
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b0, 1'b1, 1'b0, 64'h0, 1'b0},
        // R4 long mode, wide_sel 0 -> 32-bit
        '{64'hFFFF_FFFF_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0,
          64'h0000_0000_1234_5678, 1'b0},
        // R3 not long mode, wide_sel 1 ignored
        '{64'hFFFF_FFFF_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0,
          64'h0000_0000_1234_5678, 1'b0},
        // R1 both ends
        '{64'h3, 64'h8000_0000_0000_0001, 1'b1, 1'b0, 1'b1, 1'b0,
          64'h8000_0000_0000_0001, 1'b0},
        // R1 contiguous field
        '{64'h5, 64'hF0, 1'b1, 1'b0, 1'b1, 1'b0, 64'h50, 1'b0},
        // R6/R7 vector-length bit set
        '{64'hFFFF, 64'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 64'h0, 1'b1},
        // R6/R7 legacy mode
        '{64'hFFFF, 64'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 1'b1},
        // R5 upper mask half ignored in 32-bit op
        '{64'hFFFF, 64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0},
        // R4 64-bit: upper mask bits take source bits 0..1
        '{64'h2, 64'h0000_0003_0000_0000, 1'b1, 1'b0, 1'b1, 1'b0,
          64'h0000_0002_0000_0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] src_data = '0;
    logic [63:0] sel_mask = '0;
    logic        long_mode = 1'b0;
    logic        legacy_mode = 1'b0;
    logic        wide_sel = 1'b0;
    logic        vlen_bit = 1'b0;
    logic        out_valid;
    logic [63:0] res_data;
    logic        bad_op;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bit_scatter_unit #(.DATA_W(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_data(src_data), .sel_mask(sel_mask),
        .long_mode(long_mode), .legacy_mode(legacy_mode),
        .wide_sel(wide_sel), .vlen_bit(vlen_bit),
        .out_valid(out_valid), .res_data(res_data), .bad_op(bad_op)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [63:0] s, input logic [63:0] m,
                                          input bit full);
        logic [63:0] r = '0;
        int k = 0;
        int lim = full ? 64 : 32;
        for (int i = 0; i < lim; i++) begin
            if (m[i]) begin
                r[i] = s[k];
                k++;
            end
        end
        return r;
    endfunction

    task automatic issue(input vec_t v);
        @(negedge clk);
        in_valid = 1'b1;
        src_data = v.src; sel_mask = v.mask;
        long_mode = v.lm; legacy_mode = v.leg; wide_sel = v.wide; vlen_bit = v.vl;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(out_valid == 1'b0, "R9 out_valid in reset", 64'(out_valid), 64'd0);
        check(bad_op == 1'b0, "R9 bad_op in reset", 64'(bad_op), 64'd0);
        rst = 1'b0;

        // table walk
        for (int n = 0; n < NV; n++) begin
            issue(VECS[n]);
            check(out_valid == 1'b1, "R8 valid after request", 64'(out_valid), 64'd1);
            check(res_data == VECS[n].exp, "R1/R3/R4/R5/R10 table result", res_data, VECS[n].exp);
            check(bad_op == VECS[n].exp_bad, "R6 table illegal flag", 64'(bad_op), 64'(VECS[n].exp_bad));
            if (VECS[n].exp_bad)
                check(res_data == '0, "R7 illegal result zero", res_data, 64'd0);
            @(negedge clk);
            check(out_valid == 1'b0, "R8 valid drops after idle", 64'(out_valid), 64'd0);
        end

        // random sweep against loop model
        for (int n = 0; n < 300; n++) begin
            vec_t v;
            bit full;
            v.src  = {$urandom, $urandom};
            v.mask = {$urandom, $urandom};
            if (n % 4 == 1) v.mask[63:32] = '1;
            if (n % 4 == 2) v.mask[31:0]  = '1;
            if (n % 7 == 3) v.mask = '1;
            v.lm   = 1'($urandom);
            v.wide = 1'($urandom);
            v.leg  = (n % 11 == 5);
            v.vl   = (n % 13 == 6);
            full = v.lm && v.wide;
            v.exp_bad = v.leg || v.vl;
            v.exp = v.exp_bad ? 64'd0 : model(v.src, v.mask, full);
            issue(v);
            check(res_data == v.exp, "R1/R2/R5 random result", res_data, v.exp);
            check(bad_op == v.exp_bad, "R6 random illegal flag", 64'(bad_op), 64'(v.exp_bad));
        end

        // back-to-back requests keep valid high (R8)
        @(negedge clk);
        in_valid = 1'b1; src_data = 64'h1; sel_mask = 64'h4;
        long_mode = 1'b1; legacy_mode = 1'b0; wide_sel = 1'b1; vlen_bit = 1'b0;
        @(negedge clk);
        src_data = 64'h1; sel_mask = 64'h8000_0000_0000_0000;
        check(out_valid && res_data == 64'h4, "R8 first back-to-back", res_data, 64'h4);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && res_data == 64'h8000_0000_0000_0000, "R8 second back-to-back",
              res_data, 64'h8000_0000_0000_0000);

        // R9 reset drops an in-flight illegal request
        @(negedge clk);
        in_valid = 1'b1; vlen_bit = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; vlen_bit = 1'b0;
        check(out_valid == 1'b0, "R9 reset drops request valid", 64'(out_valid), 64'd0);
        check(bad_op == 1'b0, "R9 reset clears bad_op", 64'(bad_op), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 idle after reset", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule